// File: doc/BRIEF.md
# Return Address Stack

This block keeps the return addresses of a processor core in a dedicated 31-deep, 21-bit stack. When the core executes a call, a relative call or acknowledges an interrupt, it raises the push strobe together with the address of the following instruction. On any of the three return forms, it raises the pop strobe and takes the stack top as its next program counter in that same cycle. A 5-bit pointer selects the top entry. Pointer value 0 means "empty" and has no storage behind it, so the 31 entries sit at pointer values 1 to 31.

Software can manage the stack itself through a small byte-wide register port. One register holds the pointer and the two error flags. Three further registers give read and write access to the bytes of the current top entry. The block flags a full stack, a push attempted while full (overflow) and a pop attempted while empty (underflow). The two error flags are sticky.

Top module: `retstk_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the pointer is 0, both error flags are 0, full_o is 0 and tos_o is 0.
- R2: A push first increments the pointer and then writes push_pc_i into the entry that the new pointer selects. From the next cycle, tos_o shows that value.
- R3: tos_o always shows the entry that the current pointer selects, so the return address is available during the pop cycle itself. A pop decrements the pointer at that clock edge, and the pointed-to data is not changed.
- R4: full_o is 1 exactly when the pointer equals 31.
- R5: A push while the pointer is 31 sets the sticky overflow flag and leaves both the pointer and the stored entries unchanged.
- R6: A pop while the pointer is 0 sets the sticky underflow flag, sees tos_o equal to 0, and leaves the pointer at 0.
- R7: Each error flag stays set until a write to the pointer register carries a 0 in that flag's bit position. A 1 written there never sets a clear flag.
- R8: Register select 0 (reg_sel_i = 2'd0) is the pointer register. It reads as {overflow, underflow, 1'b0, pointer[4:0]}. A write to it loads the pointer from reg_wdata_i[4:0].
- R9: Register selects 1, 2 and 3 read the top entry's bits [7:0], [15:8] and [20:16] (the last zero-extended to 8 bits). A write to one of them replaces only that field of the top entry; the upper field takes reg_wdata_i[4:0].
- R10: While the pointer is 0, the three entry registers read as 0 and writes to them are ignored.
- R11: Priority within one cycle is: register write, then push, then pop. A push or pop that loses to a register write is dropped. A pop that arrives together with a push is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push strobe (call, relative call, interrupt acknowledge) |
| push_pc_i | input | 21 | Return address to push |
| pop_i | input | 1 | Pop strobe (return, return with literal, return from interrupt) |
| tos_o | output | 21 | Entry selected by the pointer, 0 when empty |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 pointer, 1 low byte, 2 high byte, 3 upper field |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| full_o | output | 1 | Pointer equals 31 |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
The timing splits into two groups:
- **Due at the next clock edge:** the pointer, the flags, full_o and the stored entries all change on the edge at which a push, pop or register write is accepted. The bench drives each stimulus one time unit after a rising edge and compares those results one time unit after the following rising edge.
- **Due in the same cycle:** tos_o and reg_rdata_o are combinational reads of the current state. The pop-return value is therefore checked after the pop has been driven but before its clock edge. Register reads are checked one time unit after the select changes.

// File: rtl/retstk_pkg.sv
package retstk_pkg;
  localparam int ADDR_W = 21;
  localparam int PTR_W  = 5;
  localparam int DEPTH  = (1 << PTR_W) - 1;
  localparam int BYTE_W = 8;
  localparam int UP_W   = ADDR_W - 2 * BYTE_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    SEL_PTR = 2'd0,
    SEL_LO  = 2'd1,
    SEL_HI  = 2'd2,
    SEL_UP  = 2'd3
  } sel_e;

  function automatic ptr_t ptr_inc(input ptr_t p);
    return p + ptr_t'(1);
  endfunction

  function automatic ptr_t ptr_dec(input ptr_t p);
    return p - ptr_t'(1);
  endfunction

  function automatic logic ptr_full(input ptr_t p);
    return p == ptr_t'(DEPTH);
  endfunction

  function automatic addr_t lane_mask(input sel_e s);
    case (s)
      SEL_LO:  return addr_t'({BYTE_W{1'b1}});
      SEL_HI:  return addr_t'({BYTE_W{1'b1}}) << BYTE_W;
      SEL_UP:  return addr_t'({UP_W{1'b1}}) << (2 * BYTE_W);
      default: return '0;
    endcase
  endfunction

  function automatic addr_t lane_spread(input byte_t b);
    return {b[UP_W-1:0], b, b};
  endfunction

  function automatic byte_t lane_pick(input addr_t v, input sel_e s);
    case (s)
      SEL_LO:  return v[BYTE_W-1:0];
      SEL_HI:  return v[2*BYTE_W-1:BYTE_W];
      SEL_UP:  return byte_t'(v[ADDR_W-1:2*BYTE_W]);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/retstk_ptr_ctrl.sv
module retstk_ptr_ctrl
  import retstk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic pop_i,
  input  logic hold_i,
  input  logic ptr_wr_i,
  input  ptr_t ptr_wdata_i,
  input  logic keep_ovf_i,
  input  logic keep_unf_i,
  output ptr_t ptr_o,
  output ptr_t ptr_nxt_o,
  output logic full_o,
  output logic ovf_o,
  output logic unf_o,
  output logic push_ok_o,
  output logic push_ovf_o,
  output logic pop_ok_o,
  output logic pop_unf_o
);
  ptr_t ptr_q;
  logic ovf_q, unf_q;
  logic push_req, pop_req, empty;

  always_comb begin
    empty      = (ptr_q == '0);
    push_req   = push_i & ~hold_i;
    pop_req    = pop_i & ~push_i & ~hold_i;
    push_ok_o  = push_req & ~ptr_full(ptr_q);
    push_ovf_o = push_req & ptr_full(ptr_q);
    pop_ok_o   = pop_req & ~empty;
    pop_unf_o  = pop_req & empty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (ptr_wr_i) begin
      ptr_q <= ptr_wdata_i;
      ovf_q <= ovf_q & keep_ovf_i;
      unf_q <= unf_q & keep_unf_i;
    end else begin
      if (push_ok_o)  ptr_q <= ptr_inc(ptr_q);
      if (pop_ok_o)   ptr_q <= ptr_dec(ptr_q);
      if (push_ovf_o) ovf_q <= 1'b1;
      if (pop_unf_o)  unf_q <= 1'b1;
    end
  end

  assign ptr_o     = ptr_q;
  assign ptr_nxt_o = ptr_inc(ptr_q);
  assign full_o    = ptr_full(ptr_q);
  assign ovf_o     = ovf_q;
  assign unf_o     = unf_q;

  assert_push_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok_o |=> ptr_q == ptr_t'($past(ptr_q) + 1'b1));
  assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok_o |=> ptr_q == ptr_t'($past(ptr_q) - 1'b1));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_ovf_o |=> ovf_q && ptr_q == ptr_t'(DEPTH));
  assert_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_unf_o |=> unf_q && ptr_q == '0);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ptr_wr_i) |=> ovf_q);
  assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_q && !ptr_wr_i) |=> unf_q);
endmodule

// File: rtl/retstk_store.sv
module retstk_store
  import retstk_pkg::*;
(
  input  logic  clk,
  input  logic  wr_en_i,
  input  ptr_t  wr_ptr_i,
  input  addr_t wr_mask_i,
  input  addr_t wr_data_i,
  input  ptr_t  rd_ptr_i,
  output addr_t rd_data_o
);
  addr_t mem [DEPTH];
  ptr_t  wr_idx, rd_idx;

  assign wr_idx = ptr_dec(wr_ptr_i);
  assign rd_idx = ptr_dec(rd_ptr_i);

  always_ff @(posedge clk) begin
    if (wr_en_i && wr_ptr_i != '0)
      mem[wr_idx] <= (mem[wr_idx] & ~wr_mask_i) | (wr_data_i & wr_mask_i);
  end

  assign rd_data_o = (rd_ptr_i == '0) ? '0 : mem[rd_idx];
endmodule

// File: rtl/retstk_top.sv
module retstk_top
  import retstk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_pc_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] tos_o,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int OVF_BIT = BYTE_W - 1;
  localparam int UNF_BIT = BYTE_W - 2;

  sel_e  sel;
  ptr_t  ptr, ptr_nxt;
  logic  push_ok, push_ovf, pop_ok, pop_unf;
  logic  ptr_wr, tos_wr;
  logic  st_wr;
  ptr_t  st_ptr;
  addr_t st_mask, st_data, top;

  assign sel    = sel_e'(reg_sel_i);
  assign ptr_wr = reg_wr_i && sel == SEL_PTR;
  assign tos_wr = reg_wr_i && sel != SEL_PTR && ptr != '0;

  retstk_ptr_ctrl u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .hold_i     (reg_wr_i),
    .ptr_wr_i   (ptr_wr),
    .ptr_wdata_i(reg_wdata_i[PTR_W-1:0]),
    .keep_ovf_i (reg_wdata_i[OVF_BIT]),
    .keep_unf_i (reg_wdata_i[UNF_BIT]),
    .ptr_o      (ptr),
    .ptr_nxt_o  (ptr_nxt),
    .full_o     (full_o),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o),
    .push_ok_o  (push_ok),
    .push_ovf_o (push_ovf),
    .pop_ok_o   (pop_ok),
    .pop_unf_o  (pop_unf)
  );

  always_comb begin
    st_wr   = push_ok | tos_wr;
    st_ptr  = push_ok ? ptr_nxt : ptr;
    st_mask = push_ok ? '1 : lane_mask(sel);
    st_data = push_ok ? push_pc_i : lane_spread(reg_wdata_i);
  end

  retstk_store u_store (
    .clk      (clk),
    .wr_en_i  (st_wr),
    .wr_ptr_i (st_ptr),
    .wr_mask_i(st_mask),
    .wr_data_i(st_data),
    .rd_ptr_i (ptr),
    .rd_data_o(top)
  );

  assign tos_o = top;

  always_comb begin
    if (sel == SEL_PTR)
      reg_rdata_o = {ovf_o, unf_o, {(BYTE_W-PTR_W-2){1'b0}}, ptr};
    else
      reg_rdata_o = lane_pick(top, sel);
  end

  assert_push_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> tos_o == $past(push_pc_i));
  assert_empty_tos_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr == '0 |-> tos_o == '0);
  assert_full_only_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !push_ok);
  assert_tos_wr_holds_ptr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tos_wr |=> $stable(ptr));
  assert_unf_pop_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_unf |-> tos_o == '0);
  assert_ovf_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ovf && !tos_wr) |=> $stable(tos_o));
endmodule

// File: tb/retstk_top_tb_top.sv
module retstk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0;
  logic [20:0] push_pc_i = '0;
  logic        pop_i = 1'b0;
  logic [20:0] tos_o;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'd0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        full_o, ovf_o, unf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  retstk_top dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_pc_i(push_pc_i),
    .pop_i(pop_i), .tos_o(tos_o), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .full_o(full_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // Vector: {op[1:0] (0 idle, 1 push, 2 pop), pc[20:0], exp_tos[20:0], exp_ptr[4:0]}
  localparam int NVEC = 11;
  localparam logic [48:0] VEC [NVEC] = '{
    {2'd1, 21'h01A34,  21'h01A34,  5'd1},
    {2'd1, 21'h00D58,  21'h00D58,  5'd2},
    {2'd1, 21'h12345,  21'h12345,  5'd3},
    {2'd2, 21'h00000,  21'h00D58,  5'd2},
    {2'd1, 21'h1FFFFF, 21'h1FFFFF, 5'd3},
    {2'd2, 21'h00000,  21'h00D58,  5'd2},
    {2'd2, 21'h00000,  21'h01A34,  5'd1},
    {2'd0, 21'h00000,  21'h01A34,  5'd1},
    {2'd2, 21'h00000,  21'h00000,  5'd0},
    {2'd1, 21'h00002,  21'h00002,  5'd1},
    {2'd2, 21'h00000,  21'h00000,  5'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, starting just after a rising edge.
  task automatic drive(input bit psh, input bit pp, input logic [20:0] pc,
                       input bit wr, input logic [1:0] sel, input logic [7:0] wd);
    push_i = psh; pop_i = pp; push_pc_i = pc;
    reg_wr_i = wr; reg_sel_i = sel; reg_wdata_i = wd;
  endtask

  task automatic finish_cycle();
    @(posedge clk);
    #1;
    push_i = 1'b0; pop_i = 1'b0; reg_wr_i = 1'b0; reg_sel_i = 2'd0;
    #1;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] val);
    reg_sel_i = sel;
    #1;
    val = reg_rdata_o;
  endtask

  function automatic logic [20:0] fill_val(input int i);
    return {5'(i), 8'(i + 64), 8'(i + 128)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(2'd0, v);
    chk("R1", "pointer reg", int'(v), 0);
    chk("R1", "tos", int'(tos_o), 0);
    chk("R1", "full", int'(full_o), 0);

    // R2 / R3 vector walk
    for (int k = 0; k < NVEC; k++) begin
      logic [1:0] op;
      op = VEC[k][48:47];
      drive(op == 2'd1, op == 2'd2, VEC[k][46:26], 1'b0, 2'd0, 8'h00);
      finish_cycle();
      rd(2'd0, v);
      chk("R2 R3", "vector tos", int'(tos_o), int'(VEC[k][25:5]));
      chk("R2 R3", "vector pointer", int'(v[4:0]), int'(VEC[k][4:0]));
    end

    // R4 fill
    for (int i = 1; i <= 31; i++) begin
      drive(1'b1, 1'b0, fill_val(i), 1'b0, 2'd0, 8'h00);
      finish_cycle();
      if (i == 30) chk("R4", "full at 30", int'(full_o), 0);
    end
    chk("R4", "full at 31", int'(full_o), 1);
    // R5 overflow
    drive(1'b1, 1'b0, 21'h00000, 1'b0, 2'd0, 8'h00);
    finish_cycle();
    chk("R5", "ovf flag", int'(ovf_o), 1);
    chk("R5", "tos kept", int'(tos_o), int'(fill_val(31)));
    rd(2'd0, v);
    chk("R8", "pointer reg after ovf", int'(v), 8'h9F);
    // R3 pop value visible during pop cycle
    drive(1'b0, 1'b1, 21'h0, 1'b0, 2'd0, 8'h00);
    #1;
    chk("R3", "pop return value", int'(tos_o), int'(fill_val(31)));
    finish_cycle();
    chk("R3", "tos after pop", int'(tos_o), int'(fill_val(30)));
    chk("R7", "ovf sticky", int'(ovf_o), 1);
    // R7 clear by write, R8 pointer load
    drive(1'b0, 1'b0, 21'h0, 1'b1, 2'd0, 8'd30);
    finish_cycle();
    chk("R7", "ovf cleared", int'(ovf_o), 0);
    drive(1'b0, 1'b0, 21'h0, 1'b1, 2'd0, 8'h83);
    finish_cycle();
    rd(2'd0, v);
    chk("R7", "write 1 does not set", int'(v), 8'h03);

    // R9 entry bytes at pointer 3
    rd(2'd1, v); chk("R9", "low byte", int'(v), 8'h83);
    rd(2'd2, v); chk("R9", "high byte", int'(v), 8'h43);
    rd(2'd3, v); chk("R9", "upper field", int'(v), 8'h03);
    drive(1'b0, 1'b0, 21'h0, 1'b1, 2'd1, 8'hAB);
    finish_cycle();
    chk("R9", "low byte write", int'(tos_o), 21'h0343AB);
    drive(1'b0, 1'b0, 21'h0, 1'b1, 2'd3, 8'hFF);
    finish_cycle();
    chk("R9", "upper write", int'(tos_o), 21'h1F43AB);
    rd(2'd3, v); chk("R9", "upper read", int'(v), 8'h1F);

    // R11 priorities
    drive(1'b1, 1'b0, 21'h11111, 1'b1, 2'd0, 8'd5);
    finish_cycle();
    rd(2'd0, v);
    chk("R11", "write beats push ptr", int'(v), 5);
    chk("R11", "write beats push tos", int'(tos_o), int'(fill_val(5)));
    drive(1'b1, 1'b1, 21'h0ABCD, 1'b0, 2'd0, 8'h00);
    finish_cycle();
    rd(2'd0, v);
    chk("R11", "push beats pop ptr", int'(v), 6);
    chk("R11", "push beats pop tos", int'(tos_o), 21'h0ABCD);
    drive(1'b0, 1'b1, 21'h0, 1'b1, 2'd2, 8'h77);
    finish_cycle();
    rd(2'd0, v);
    chk("R11", "write beats pop ptr", int'(v), 6);
    chk("R11", "write beats pop tos", int'(tos_o), 21'h077CD);

    // R10 empty pointer
    drive(1'b0, 1'b0, 21'h0, 1'b1, 2'd0, 8'h00);
    finish_cycle();
    rd(2'd1, v); chk("R10", "empty read", int'(v), 0);
    drive(1'b0, 1'b0, 21'h0, 1'b1, 2'd1, 8'h55);
    finish_cycle();
    // R6 underflow
    drive(1'b0, 1'b1, 21'h0, 1'b0, 2'd0, 8'h00);
    #1;
    chk("R6", "pop value when empty", int'(tos_o), 0);
    finish_cycle();
    rd(2'd0, v);
    chk("R6", "unf set ptr 0", int'(v), 8'h40);
    chk("R6", "unf port", int'(unf_o), 1);
    drive(1'b0, 1'b0, 21'h0, 1'b1, 2'd0, 8'h41);
    finish_cycle();
    chk("R10", "entry 1 untouched", int'(tos_o), int'(fill_val(1)));
    chk("R7", "unf kept by write 1", int'(unf_o), 1);
    drive(1'b0, 1'b0, 21'h0, 1'b1, 2'd0, 8'h01);
    finish_cycle();
    rd(2'd0, v);
    chk("R7", "unf cleared", int'(v), 8'h01);

    // R1 reset again mid-run
    rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    rd(2'd0, v);
    chk("R1", "second reset pointer reg", int'(v), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule